// File: doc/BRIEF.md
# Error Log Bank with Severity-Based Overwrite

This block is one hardware error-logging bank. Each error event arrives as a one-cycle strobe with a class code, an address and a syndrome. If the bank is empty, the event is stored. If the bank already holds a valid record, the block sets the overflow flag. It then compares the severity of the two events and decides whether the incoming payload replaces the stored one. Replacement follows severity, not arrival order.

The status flags collect across events. The uncorrected, context-corrupt, signalling and action-required flags of a later event are ORed into the stored flags. A later event therefore never clears them, even when its payload replaces the stored one. A reset-required output tells software that the logged condition needs a system reset. A clear strobe from software empties the bank.

Top module: `errbank_log`

## Requirements
- R1: After reset, all status flags, the address, the syndrome and `reset_req` are 0.
- R2: Class codes and their flags (uc, pcc, sig, act):
  - 0 = corrected: 0,0,0,0
  - 1 = recoverable, no action: 1,0,0,0
  - 2 = recoverable, optional action: 1,0,1,0
  - 3 = recoverable, action required: 1,0,1,1
  - 4 = fatal: 1,1,0,0
  - 5 to 7 are handled as fatal.
  An event that reaches an empty bank is stored with exactly its own flags, valid=1 and overflow=0.
- R3: Severity ranks are corrected < recoverable (codes 1 to 3) < fatal. An incoming event of strictly higher rank than the stored record replaces the address and syndrome.
- R4: An incoming event of equal or lower rank leaves the stored address and syndrome unchanged; the first record is kept.
- R5: Any event that arrives while the bank is valid sets the overflow flag, whether or not the payload is replaced.
- R6: After a second event, uc, pcc, sig and act each equal the OR of the stored and incoming values. Once set, a flag stays set until a clear.
- R7: `reset_req` is 1 exactly when the bank is valid and either act or pcc is 1.
- R8: A clear strobe zeroes all flags and the payload in one cycle. An event in the same cycle as the clear is logged as a first event: its own flags, overflow=0.
- R9: Every status and payload output reflects an event or clear on the first rising edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_valid | input | 1 | Error event strobe |
| evt_class | input | CLASS_W | Event class code (see R2) |
| evt_addr | input | ADDR_W | Event address payload |
| evt_synd | input | SYND_W | Event syndrome payload |
| clr | input | 1 | Software clear strobe |
| log_valid | output | 1 | Bank holds a record |
| log_over | output | 1 | A second event arrived while the bank was valid |
| log_uc | output | 1 | Uncorrected flag |
| log_pcc | output | 1 | Context-corrupt flag |
| log_sig | output | 1 | Signalling flag |
| log_act | output | 1 | Action-required flag |
| log_addr | output | ADDR_W | Stored address |
| log_synd | output | SYND_W | Stored syndrome |
| reset_req | output | 1 | System reset required |

## Verification
Every stored flag and payload field is a single register stage. A result is therefore due one cycle after the edge that samples the event or clear. `reset_req` is combinational from those registers, so it is due in the same cycle as the flags.

The bench changes inputs on falling edges and holds each strobe for exactly one cycle. It reads the outputs on the next falling edge, halfway between the capturing edge and the following one.

The sweep covers every ordered pair of the eight class codes with distinct payloads. It also checks triple-event stickiness, a clear on its own, and a clear that coincides with an event.

// File: rtl/errbank_pkg.sv
package errbank_pkg;

   typedef struct packed {
      logic uc;
      logic pcc;
      logic sig;
      logic act;
   } errflags_t;

   localparam errflags_t FLAGS_NONE = '{uc: 1'b0, pcc: 1'b0, sig: 1'b0, act: 1'b0};

   localparam logic [1:0] RANK_CORR  = 2'd0;
   localparam logic [1:0] RANK_RECOV = 2'd1;
   localparam logic [1:0] RANK_FATAL = 2'd2;

   function automatic logic [1:0] rank_of(errflags_t f);
      if (f.pcc)     return RANK_FATAL;
      else if (f.uc) return RANK_RECOV;
      else           return RANK_CORR;
   endfunction

endpackage

// File: rtl/errbank_classify.sv
module errbank_classify
   import errbank_pkg::*;
#(
   parameter int CLASS_W          = 3,
   parameter bit UNKNOWN_AS_FATAL = 1'b1
) (
   input  logic [CLASS_W-1:0] cls,
   output errflags_t          flags,
   output logic               known
);

   localparam int CODE_CORR  = 0;
   localparam int CODE_UNA   = 1;
   localparam int CODE_OPT   = 2;
   localparam int CODE_REQ   = 3;
   localparam int CODE_FATAL = 4;

   errflags_t base_flags;
   logic      base_known;

   always_comb begin
      base_flags = FLAGS_NONE;
      base_known = 1'b1;
      if (cls == CLASS_W'(CODE_CORR)) begin
         base_flags = FLAGS_NONE;
      end else if (cls == CLASS_W'(CODE_UNA)) begin
         base_flags.uc = 1'b1;
      end else if (cls == CLASS_W'(CODE_OPT)) begin
         base_flags.uc  = 1'b1;
         base_flags.sig = 1'b1;
      end else if (cls == CLASS_W'(CODE_REQ)) begin
         base_flags.uc  = 1'b1;
         base_flags.sig = 1'b1;
         base_flags.act = 1'b1;
      end else if (cls == CLASS_W'(CODE_FATAL)) begin
         base_flags.uc  = 1'b1;
         base_flags.pcc = 1'b1;
      end else begin
         base_known     = 1'b0;
         base_flags.uc  = 1'b1;
         base_flags.pcc = 1'b1;
      end
   end

   generate
      if (UNKNOWN_AS_FATAL) begin : g_unknown_fatal
         assign flags = base_flags;
         assign known = 1'b1;
      end else begin : g_unknown_drop
         assign flags = base_known ? base_flags : FLAGS_NONE;
         assign known = base_known;
      end
   endgenerate

endmodule

// File: rtl/errbank_merge.sv
module errbank_merge
   import errbank_pkg::*;
(
   input  logic      cur_valid,
   input  logic      cur_over,
   input  errflags_t cur_flags,
   input  logic      evt_take,
   input  errflags_t evt_flags,
   input  logic      clr,
   output logic      nxt_valid,
   output logic      nxt_over,
   output errflags_t nxt_flags,
   output logic      load_payload,
   output logic      zero_payload
);

   logic      base_valid;
   logic      base_over;
   errflags_t base_flags;

   always_comb begin
      base_valid = cur_valid & ~clr;
      base_over  = cur_over  & ~clr;
      base_flags = clr ? FLAGS_NONE : cur_flags;
   end

   always_comb begin
      nxt_valid    = base_valid;
      nxt_over     = base_over;
      nxt_flags    = base_flags;
      load_payload = 1'b0;
      zero_payload = clr;
      if (evt_take) begin
         if (!base_valid) begin
            nxt_valid    = 1'b1;
            nxt_over     = 1'b0;
            nxt_flags    = evt_flags;
            load_payload = 1'b1;
         end else begin
            nxt_over     = 1'b1;
            nxt_flags    = base_flags | evt_flags;
            load_payload = rank_of(evt_flags) > rank_of(base_flags);
         end
      end
   end

endmodule

// File: rtl/errbank_regs.sv
module errbank_regs
   import errbank_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int SYND_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nxt_valid,
   input  logic              nxt_over,
   input  errflags_t         nxt_flags,
   input  logic              load_payload,
   input  logic              zero_payload,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [SYND_W-1:0] in_synd,
   output logic              q_valid,
   output logic              q_over,
   output errflags_t         q_flags,
   output logic [ADDR_W-1:0] q_addr,
   output logic [SYND_W-1:0] q_synd
);

   localparam int PAY_W = ADDR_W + SYND_W;

   logic [PAY_W-1:0] pay_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
         q_over  <= 1'b0;
         q_flags <= FLAGS_NONE;
      end else begin
         q_valid <= nxt_valid;
         q_over  <= nxt_over;
         q_flags <= nxt_flags;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pay_q <= '0;
      end else if (load_payload) begin
         pay_q <= {in_addr, in_synd};
      end else if (zero_payload) begin
         pay_q <= '0;
      end
   end

   assign q_addr = pay_q[PAY_W-1:SYND_W];
   assign q_synd = pay_q[SYND_W-1:0];

endmodule

// File: rtl/errbank_log.sv
module errbank_log
   import errbank_pkg::*;
#(
   parameter int ADDR_W           = 16,
   parameter int SYND_W           = 8,
   parameter int CLASS_W          = 3,
   parameter bit UNKNOWN_AS_FATAL = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               evt_valid,
   input  logic [CLASS_W-1:0] evt_class,
   input  logic [ADDR_W-1:0]  evt_addr,
   input  logic [SYND_W-1:0]  evt_synd,
   input  logic               clr,
   output logic               log_valid,
   output logic               log_over,
   output logic               log_uc,
   output logic               log_pcc,
   output logic               log_sig,
   output logic               log_act,
   output logic [ADDR_W-1:0]  log_addr,
   output logic [SYND_W-1:0]  log_synd,
   output logic               reset_req
);

   generate
      if (CLASS_W < 3) begin : g_bad_class_w
         $error("errbank_log: CLASS_W must be at least 3");
      end
      if (ADDR_W < 1 || SYND_W < 1) begin : g_bad_pay_w
         $error("errbank_log: payload widths must be positive");
      end
   endgenerate

   errflags_t evt_flags;
   logic      evt_known;
   logic      nxt_valid, nxt_over, load_payload, zero_payload;
   errflags_t nxt_flags;
   logic      q_valid, q_over;
   errflags_t q_flags;

   errbank_classify #(
      .CLASS_W          (CLASS_W),
      .UNKNOWN_AS_FATAL (UNKNOWN_AS_FATAL)
   ) u_classify (
      .cls   (evt_class),
      .flags (evt_flags),
      .known (evt_known)
   );

   errbank_merge u_merge (
      .cur_valid    (q_valid),
      .cur_over     (q_over),
      .cur_flags    (q_flags),
      .evt_take     (evt_valid & evt_known),
      .evt_flags    (evt_flags),
      .clr          (clr),
      .nxt_valid    (nxt_valid),
      .nxt_over     (nxt_over),
      .nxt_flags    (nxt_flags),
      .load_payload (load_payload),
      .zero_payload (zero_payload)
   );

   errbank_regs #(
      .ADDR_W (ADDR_W),
      .SYND_W (SYND_W)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .nxt_valid    (nxt_valid),
      .nxt_over     (nxt_over),
      .nxt_flags    (nxt_flags),
      .load_payload (load_payload),
      .zero_payload (zero_payload),
      .in_addr      (evt_addr),
      .in_synd      (evt_synd),
      .q_valid      (q_valid),
      .q_over       (q_over),
      .q_flags      (q_flags),
      .q_addr       (log_addr),
      .q_synd       (log_synd)
   );

   assign log_valid = q_valid;
   assign log_over  = q_over;
   assign log_uc    = q_flags.uc;
   assign log_pcc   = q_flags.pcc;
   assign log_sig   = q_flags.sig;
   assign log_act   = q_flags.act;
   assign reset_req = q_valid & (q_flags.act | q_flags.pcc);

endmodule

// File: rtl/errbank_log_chk.sv
module errbank_log_chk #(
   parameter int ADDR_W  = 16,
   parameter int SYND_W  = 8,
   parameter int CLASS_W = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               evt_valid,
   input logic [CLASS_W-1:0] evt_class,
   input logic [ADDR_W-1:0]  evt_addr,
   input logic               clr,
   input logic               log_valid,
   input logic               log_over,
   input logic               log_uc,
   input logic               log_pcc,
   input logic               log_sig,
   input logic               log_act,
   input logic [ADDR_W-1:0]  log_addr,
   input logic               reset_req
);

   logic evt_recov;
   assign evt_recov = (evt_class >= CLASS_W'(1)) && (evt_class <= CLASS_W'(3));

   // R5: second event while valid always flags overflow
   assert_over_on_second_R5: assert property (@(posedge clk) disable iff (!rst_n)
      log_valid && evt_valid && !clr |=> log_over);

   // R2: first event into an empty bank never flags overflow
   assert_first_no_over_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !log_valid && evt_valid |=> log_valid && !log_over);

   // R6: sticky signalling and action-required flags
   assert_sig_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      log_sig && !clr |=> log_sig);
   assert_act_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      log_act && !clr |=> log_act);

   // R4: a stored recoverable record keeps its address against corrected or recoverable events
   assert_keep_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      log_valid && log_uc && !log_pcc && evt_valid && !clr &&
      (evt_class <= CLASS_W'(3)) |=> $stable(log_addr));

   // R3: recoverable event replaces a stored corrected record
   assert_replace_corr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      log_valid && !log_uc && evt_valid && evt_recov && !clr |=> log_addr == $past(evt_addr));

   // R8: a clear with no event empties the bank
   assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr && !evt_valid |=> !log_valid && !log_over && !log_uc && !log_sig && !log_act);

   // R7: context corruption demands a reset
   assert_pcc_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
      log_valid && log_pcc |-> reset_req);

endmodule

bind errbank_log errbank_log_chk #(
   .ADDR_W  (ADDR_W),
   .SYND_W  (SYND_W),
   .CLASS_W (CLASS_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .evt_valid (evt_valid),
   .evt_class (evt_class),
   .evt_addr  (evt_addr),
   .clr       (clr),
   .log_valid (log_valid),
   .log_over  (log_over),
   .log_uc    (log_uc),
   .log_pcc   (log_pcc),
   .log_sig   (log_sig),
   .log_act   (log_act),
   .log_addr  (log_addr),
   .reset_req (reset_req)
);

// File: tb/tb_errbank_log.sv
`timescale 1ns/1ps
module tb_errbank_log;

   localparam int ADDR_W  = 16;
   localparam int SYND_W  = 8;
   localparam int CLASS_W = 3;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               evt_valid = 1'b0;
   logic [CLASS_W-1:0] evt_class = '0;
   logic [ADDR_W-1:0]  evt_addr = '0;
   logic [SYND_W-1:0]  evt_synd = '0;
   logic               clr = 1'b0;
   logic               log_valid, log_over, log_uc, log_pcc, log_sig, log_act, reset_req;
   logic [ADDR_W-1:0]  log_addr;
   logic [SYND_W-1:0]  log_synd;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;   // 125 MHz

   errbank_log #(.ADDR_W(ADDR_W), .SYND_W(SYND_W), .CLASS_W(CLASS_W)) dut (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_class(evt_class),
      .evt_addr(evt_addr), .evt_synd(evt_synd), .clr(clr),
      .log_valid(log_valid), .log_over(log_over), .log_uc(log_uc), .log_pcc(log_pcc),
      .log_sig(log_sig), .log_act(log_act), .log_addr(log_addr), .log_synd(log_synd),
      .reset_req(reset_req)
   );

   // class flags per R2, packed as {uc,pcc,sig,act}
   function automatic logic [3:0] cls_flags(int c);
      case (c)
         0: return 4'b0000;
         1: return 4'b1000;
         2: return 4'b1010;
         3: return 4'b1011;
         default: return 4'b1100;
      endcase
   endfunction

   function automatic int cls_rank(int c);
      if (c == 0) return 0;
      if (c <= 3) return 1;
      return 2;
   endfunction

   task automatic chk(string req, string what, longint act_v, longint exp_v);
      checks++;
      if (act_v != exp_v) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act_v, exp_v);
      end
   endtask

   task automatic chk_state(string req, logic v, logic o, logic [3:0] f,
                            logic [ADDR_W-1:0] a, logic [SYND_W-1:0] s);
      chk(req, "valid", log_valid, v);
      chk(req, "over", log_over, o);
      chk(req, "flags", {log_uc, log_pcc, log_sig, log_act}, f);
      chk(req, "addr", log_addr, a);
      chk(req, "synd", log_synd, s);
      chk("R7", "reset_req", reset_req, v & (f[0] | f[2]));
   endtask

   // drive on negedge, one-cycle strobe, output due after the next posedge (R9)
   task automatic send(int c, logic [ADDR_W-1:0] a, logic [SYND_W-1:0] s, logic with_clr);
      evt_valid = 1'b1;
      evt_class = CLASS_W'(c);
      evt_addr  = a;
      evt_synd  = s;
      clr       = with_clr;
      @(negedge clk);
      evt_valid = 1'b0;
      clr       = 1'b0;
   endtask

   task automatic do_clear();
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
   endtask

   initial begin : watchdog
      #1000000;
      fails++;
      $display("FAIL watchdog expired: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : stim
      logic [3:0] ef;
      logic [ADDR_W-1:0] a1, a2;
      logic [SYND_W-1:0] s1, s2;
      @(negedge clk);
      @(negedge clk);
      chk_state("R1", 1'b0, 1'b0, 4'b0000, '0, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_state("R1", 1'b0, 1'b0, 4'b0000, '0, '0);

      for (int a = 0; a < 8; a++) begin
         for (int b = 0; b < 8; b++) begin
            a1 = ADDR_W'(16'h1000 + a * 16 + b);
            s1 = SYND_W'(8'h10 + a);
            a2 = ADDR_W'(16'h8000 + a * 16 + b);
            s2 = SYND_W'(8'hA0 + b);
            send(a, a1, s1, 1'b0);
            chk_state("R2", 1'b1, 1'b0, cls_flags(a), a1, s1);
            send(b, a2, s2, 1'b0);
            ef = cls_flags(a) | cls_flags(b);
            if (cls_rank(b) > cls_rank(a))
               chk_state("R3", 1'b1, 1'b1, ef, a2, s2);
            else
               chk_state("R4", 1'b1, 1'b1, ef, a1, s1);
            chk("R5", "over", log_over, 1'b1);
            chk("R6", "flags", {log_uc, log_pcc, log_sig, log_act}, ef);
            do_clear();
            chk_state("R8", 1'b0, 1'b0, 4'b0000, '0, '0);
         end
      end

      // R6: three events; sticky sig/act survive a fatal overwrite
      send(3, 16'h0A0A, 8'h0A, 1'b0);
      send(2, 16'h0B0B, 8'h0B, 1'b0);
      send(4, 16'h0C0C, 8'h0C, 1'b0);
      chk_state("R6", 1'b1, 1'b1, 4'b1111, 16'h0C0C, 8'h0C);
      send(0, 16'h0D0D, 8'h0D, 1'b0);
      chk_state("R6", 1'b1, 1'b1, 4'b1111, 16'h0C0C, 8'h0C);

      // R8: clear with coincident event logs it as first
      send(1, 16'h0E0E, 8'h0E, 1'b1);
      chk_state("R8", 1'b1, 1'b0, 4'b1000, 16'h0E0E, 8'h0E);
      // R7: no-action plus optional never asks for reset
      send(2, 16'h0F0F, 8'h0F, 1'b0);
      chk_state("R7", 1'b1, 1'b1, 4'b1010, 16'h0E0E, 8'h0E);
      // R9: output holds with no stimulus
      @(negedge clk);
      chk_state("R9", 1'b1, 1'b1, 4'b1010, 16'h0E0E, 8'h0E);
      do_clear();
      chk_state("R8", 1'b0, 1'b0, 4'b0000, '0, '0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule